// File: doc/BRIEF.md
# Auto-Test Excitation Sequencer

This block runs the built-in excitation test of a chamber read-out chain. After a start command it walks a sine table through 128 phase steps per period, for three periods. For each step it offers the sample word to a DAC stream. It then waits for one response word from every one of 16 channels on a second stream. Each response is written into four dual-port buffers of 128 words of 32 bits. Each response is also compared with the amplitude expected for that step, inside a window that software sets.

The pace of the test comes from a slot prescaler. After each completed step, the next sample is held back for a programmed number of clock cycles. With a 100 MHz clock, a value near 2.6 million gives the roughly 26 ms slot of a 0.3 Hz excitation. A full run of 16 boards is then about 160 s, with the boards tested one after another. When the last step of the final period completes, `done` pulses for one cycle and the block returns to idle. `test_fail` holds the verdict until the next start.

Both streams are valid/ready. The DAC stream holds its word until the consumer takes it, so a slow DAC stretches the slot without losing a sample. The block raises `resp_ready` only after its sample has been taken. The block never drops a response, and a response source that stalls simply pauses the run.

Top module: `exc_autotest_seq`

## Requirements
- R1: After reset `dac_valid`, `resp_ready`, `done`, `test_fail` and all `buf_we` bits are 0, and the block is idle.
- R2: `start` high while idle begins a run at phase 0, period 0, and clears `test_fail`; `start` during a run has no effect on the sample sequence or on the run length.
- R3: `dac_valid` rises exactly max(`tick_div`,1) clock cycles after the edge that accepted `start` or completed the previous response handshake.
- R4: The sample of phase p (0..127) is, with H=64, x=p mod H and q=x(H−x): mag=floor(32767·16q/(5H²−4q)), code=32768+mag for p<64 and 32768−mag otherwise. The phase advances by one per step and wraps from 127 to 0 at each new period.
- R5: While `dac_valid` is high and `dac_ready` is low, `dac_valid` stays high and `dac_data` is stable. After the DAC handshake `resp_ready` is high until a response handshake, and no new sample is offered meanwhile.
- R6: In the cycle of a response handshake, `buf_we` is all ones, `buf_addr` equals the phase and `buf_wdata` equals `resp_data`. Channel c occupies bits [8c+7:8c], so buffer b receives bits [32b+31:32b]. Outside a handshake `buf_we` is 0.
- R7: After 384 response handshakes `done` is high for exactly one cycle, the cycle after the final handshake, and the block is idle again; `done` never rises earlier.
- R8: For each channel, the expected byte e is bits [15:8] of the current sample. A response r violates if r > e+`thr_hi` or r+`thr_lo` < e, computed without wrap. A violation sets `test_fail` on the next cycle, and values exactly on a bound pass.
- R9: `test_fail` is sticky: once set it stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| tick_div | input | 24 | Wait cycles before each sample (0 acts as 1) |
| thr_hi | input | 8 | Allowed excess of a response over the expected byte |
| thr_lo | input | 8 | Allowed shortfall of a response under the expected byte |
| dac_valid | output | 1 | Sample word offered |
| dac_ready | input | 1 | DAC side takes the word |
| dac_data | output | 16 | Offset-binary sample word |
| resp_valid | input | 1 | Response set present |
| resp_ready | output | 1 | Block accepts the response set |
| resp_data | input | 128 | 16 channels of 8 bits, channel c at bits 8c |
| buf_we | output | 4 | Write enable of each buffer |
| buf_addr | output | 7 | Buffer word address (phase) |
| buf_wdata | output | 128 | Write data, buffer b at bits 32b |
| done | output | 1 | One-cycle end-of-run pulse |
| test_fail | output | 1 | Sticky window violation flag |

## Verification
Every run is checked against the full 384-sample sequence. Random ready stalls on the DAC side and random response delays separate correct flow control from a block that drops or repeats samples. Random responses inside the window must leave the flag clear. Responses placed exactly on both bounds tell an inclusive comparison from an off-by-one one. Single values one step beyond the upper or lower bound must set the flag and keep it set. Runs with prescaler values 0, 1, 2 and 3 pin the slot gap. A start pulse in mid-run shows whether the sequencer wrongly restarts.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_COLLECT
  } seq_state_e;

  // Rational sine approximation over one half-wave, offset binary.
  function automatic longint unsigned sine_code(input longint unsigned p,
                                                input longint unsigned n,
                                                input longint unsigned dw);
    longint unsigned half, x, q, amp, mid, mag;
    half = n / 2;
    x    = p % half;
    q    = x * (half - x);
    amp  = (longint'(1) << (dw - 1)) - 1;
    mid  = longint'(1) << (dw - 1);
    mag  = (amp * 16 * q) / (5 * half * half - 4 * q);
    return (p < half) ? (mid + mag) : (mid - mag);
  endfunction

endpackage

// File: rtl/exc_sine_rom.sv
module exc_sine_rom #(
  parameter int SAMPLES = 128,
  parameter int DW      = 16,
  localparam int AW     = $clog2(SAMPLES)
) (
  input  logic [AW-1:0] idx,
  output logic [DW-1:0] code
);
  import exc_pkg::*;

  logic [DW-1:0] tbl [SAMPLES];

  for (genvar i = 0; i < SAMPLES; i++) begin : g_tbl
    assign tbl[i] = DW'(sine_code(longint'(i), longint'(SAMPLES), longint'(DW)));
  end

  assign code = tbl[idx];
endmodule

// File: rtl/exc_slot_timer.sv
module exc_slot_timer #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          run,
  input  logic [PW-1:0] limit,
  output logic          fire
);
  logic [PW-1:0] cnt;
  logic [PW:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign fire   = run && (cnt_nx >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n || arm) cnt <= '0;
    else if (run)      cnt <= fire ? '0 : cnt_nx[PW-1:0];
  end

  // R3: a slot never fires before at least one waiting cycle after arming
  a_r3_no_fire_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !fire || ({1'b0, limit} <= 1));
endmodule

// File: rtl/exc_resp_check.sv
module exc_resp_check #(
  parameter int N_CH = 16,
  parameter int RW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [RW-1:0]    expected,
  input  logic [RW-1:0]    thr_hi,
  input  logic [RW-1:0]    thr_lo,
  input  logic [N_CH*RW-1:0] resp,
  output logic             fail
);
  logic [N_CH-1:0] viol;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [RW:0] r, e, hi_b, lo_b;
    assign r    = {1'b0, resp[c*RW +: RW]};
    assign e    = {1'b0, expected};
    assign hi_b = e + {1'b0, thr_hi};
    assign lo_b = r + {1'b0, thr_lo};
    assign viol[c] = (r > hi_b) || (lo_b < e);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)   fail <= 1'b0;
    else if (take && |viol) fail <= 1'b1;
  end

  // R9: flag stays set until cleared by a new run
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clear |=> fail);
  // R8: a flagged violation sets the flag
  a_r8_viol_sets: assert property (@(posedge clk) disable iff (!rst_n)
    take && (viol != '0) && !clear |=> fail);
endmodule

// File: rtl/exc_autotest_seq.sv
module exc_autotest_seq #(
  parameter int SAMPLES = 128,
  parameter int PERIODS = 3,
  parameter int N_CH    = 16,
  parameter int DW      = 16,
  parameter int RW      = 8,
  parameter int WORD_W  = 32,
  parameter int PW      = 24,
  localparam int AW     = $clog2(SAMPLES),
  localparam int N_BLK  = (N_CH * RW) / WORD_W,
  localparam int PCW    = (PERIODS > 1) ? $clog2(PERIODS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PW-1:0]           tick_div,
  input  logic [RW-1:0]           thr_hi,
  input  logic [RW-1:0]           thr_lo,
  output logic                    dac_valid,
  input  logic                    dac_ready,
  output logic [DW-1:0]           dac_data,
  input  logic                    resp_valid,
  output logic                    resp_ready,
  input  logic [N_CH*RW-1:0]      resp_data,
  output logic [N_BLK-1:0]        buf_we,
  output logic [AW-1:0]           buf_addr,
  output logic [N_BLK*WORD_W-1:0] buf_wdata,
  output logic                    done,
  output logic                    test_fail
);
  import exc_pkg::*;

  seq_state_e     state;
  logic [AW-1:0]  phase;
  logic [PCW-1:0] period;
  logic           start_ok, dac_hs, resp_hs, last_step, fire;

  assign start_ok  = (state == ST_IDLE) && start;
  assign dac_valid = (state == ST_SEND);
  assign resp_ready = (state == ST_COLLECT);
  assign dac_hs    = dac_valid && dac_ready;
  assign resp_hs   = resp_valid && resp_ready;
  assign last_step = (phase == AW'(SAMPLES - 1)) && (period == PCW'(PERIODS - 1));

  exc_sine_rom #(.SAMPLES(SAMPLES), .DW(DW)) u_rom (
    .idx  (phase),
    .code (dac_data)
  );

  exc_slot_timer #(.PW(PW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (start_ok || resp_hs),
    .run   (state == ST_WAIT),
    .limit (tick_div),
    .fire  (fire)
  );

  exc_resp_check #(.N_CH(N_CH), .RW(RW)) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .take     (resp_hs),
    .expected (dac_data[DW-1 -: RW]),
    .thr_hi   (thr_hi),
    .thr_lo   (thr_lo),
    .resp     (resp_data),
    .fail     (test_fail)
  );

  assign buf_we    = {N_BLK{resp_hs}};
  assign buf_addr  = phase;
  assign buf_wdata = resp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= '0;
      period <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_WAIT;
          phase  <= '0;
          period <= '0;
        end
        ST_WAIT: if (fire) state <= ST_SEND;
        ST_SEND: if (dac_hs) state <= ST_COLLECT;
        ST_COLLECT: if (resp_hs) begin
          if (last_step) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_WAIT;
            if (phase == AW'(SAMPLES - 1)) begin
              phase  <= '0;
              period <= period + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: an offered sample is held, unchanged, until taken
  a_r5_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && !dac_ready |=> dac_valid && $stable(dac_data));
  // R5: after the sample is taken the block listens for responses
  a_r5_collect_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && dac_ready |=> resp_ready && !dac_valid);
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: completion only follows a response handshake
  a_r7_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(resp_valid && resp_ready));
endmodule

// File: tb/exc_autotest_seq_tb.sv
module exc_autotest_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [23:0]  tick_div = '0;
  logic [7:0]   thr_hi = '0, thr_lo = '0;
  logic         dac_valid, dac_ready = 1'b0;
  logic [15:0]  dac_data;
  logic         resp_valid = 1'b0, resp_ready;
  logic [127:0] resp_data = '0;
  logic [3:0]   buf_we;
  logic [6:0]   buf_addr;
  logic [127:0] buf_wdata;
  logic         done, test_fail;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_autotest_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_div(tick_div),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .dac_valid(dac_valid),
    .dac_ready(dac_ready), .dac_data(dac_data), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .done(done),
    .test_fail(test_fail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int model_code(input int p);
    real h, x, q, m;
    h = 64.0;
    x = (p < 64) ? real'(p) : real'(p - 64);
    q = x * (h - x);
    m = $floor(32767.0 * 16.0 * q / (5.0 * h * h - 4.0 * q));
    return (p < 64) ? 32768 + int'(m) : 32768 - int'(m);
  endfunction

  function automatic int clampb(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  // mode 0 random in window, 1 on bounds, 2 one over at step 130, 3 one under
  function automatic logic [127:0] make_resp(input int n, input int mode,
                                             input int hi, input int lo);
    logic [127:0] d;
    int e, v;
    e = model_code(n % 128) >> 8;
    for (int c = 0; c < 16; c++) begin
      v = e + int'($urandom % (hi + lo + 1)) - lo;
      if (mode == 1) v = (c % 2 == 0) ? e + hi : e - lo;
      if (mode == 2 && n == 130 && c == 5)  v = e + hi + 1;
      if (mode == 3 && n == 130 && c == 11) v = e - lo - 1;
      d[c*8 +: 8] = 8'(clampb(v));
    end
    return d;
  endfunction

  task automatic run_test(input int tick, input int hi, input int lo,
                          input int mode, input bit exp_fail);
    int n = 0, g = 0, delay = 0, cyc = 0, gap;
    bit seen = 0, fin = 0, rfire;
    tick_div = 24'(tick); thr_hi = 8'(hi); thr_lo = 8'(lo);
    gap = (tick < 1) ? 1 : tick;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(test_fail == 1'b0, "R9", "flag cleared by start", test_fail, 0);
    check(dac_valid == 1'b0, "R3", "no sample right after start", dac_valid, 0);
    while (!fin && cyc < 40000) begin
      rfire = 0;
      cyc++;
      if (done) begin
        check(n == 384, "R7", "steps before done", n, 384);
        check(test_fail == exp_fail, "R9", "verdict at done", test_fail, exp_fail);
        check(resp_ready == 1'b0 && dac_valid == 1'b0, "R7", "idle after done", resp_ready, 0);
        fin = 1;
      end else if (dac_valid) begin
        if (!seen) begin
          seen = 1;
          check(g == gap, "R3", "slot gap", g, gap);
          check(int'(dac_data) == model_code(n % 128), "R4", "sample word",
                dac_data, model_code(n % 128));
        end
        dac_ready = ($urandom % 4) != 0;
      end else if (resp_ready) begin
        if (delay > 0) delay--;
        else begin
          resp_valid = 1'b1;
          resp_data  = make_resp(n, mode, hi, lo);
          #1;
          check(buf_we == 4'hF, "R6", "write enables", buf_we, 4'hF);
          check(buf_addr == 7'(n % 128), "R6", "buffer address", buf_addr, n % 128);
          check(buf_wdata == resp_data, "R6", "buffer data", buf_wdata[63:0], resp_data[63:0]);
          rfire = 1;
        end
      end else if (mode == 0 && n == 200 && g == 0) begin
        start = 1'b1;  // R2: start mid-run must be ignored
      end
      @(negedge clk);
      start = 1'b0;
      dac_ready = 1'b0;
      if (fin) begin
        check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
      end else if (rfire) begin
        resp_valid = 1'b0;
        if (mode >= 2 && n == 130)
          check(test_fail == 1'b1, "R8", "violation flagged", test_fail, 1);
        if (mode >= 2 && n == 300)
          check(test_fail == 1'b1, "R9", "flag still set", test_fail, 1);
        if (mode == 1 && n == 200)
          check(test_fail == 1'b0, "R8", "bounds pass", test_fail, 0);
        n++; g = 0; seen = 0; delay = int'($urandom % 3);
        check(buf_we == 4'h0, "R6", "no write after handshake", buf_we, 0);
      end else begin
        g++;
      end
    end
    check(fin, "R7", "run completed", fin, 1);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(dac_valid == 0 && resp_ready == 0 && done == 0 && test_fail == 0 && buf_we == 0,
          "R1", "reset outputs", {dac_valid, resp_ready, done, test_fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_valid == 0 && resp_ready == 0, "R1", "idle without start",
          {dac_valid, resp_ready}, 0);
    run_test(3, 6, 6, 0, 1'b0);   // R2 restart ignored, R4 sequence
    run_test(0, 4, 4, 1, 1'b0);   // R8 boundaries, R3 zero prescale
    run_test(2, 5, 3, 2, 1'b1);   // R8 over the top, R9 sticky
    run_test(1, 3, 5, 3, 1'b1);   // R9 cleared at start, R8 under
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule